// File: doc/BRIEF.md
# Dual Timer Wrapper

This block places two independent down-counting timer channels behind one 4 KB register window and merges their interrupts. Each channel has its own tick-enable input, so the two can run at different rates taken from any strobe source in the system. A channel counts down on qualified ticks, with an optional divide-by-16 or divide-by-256 prescaler. When it steps from zero it raises its interrupt and then reloads, stops, or wraps to all ones, depending on its mode.

The host reaches the block through a plain strobe interface. A read returns data combinationally in the cycle `bus_sel` is high and `bus_wr` is low. A write takes effect at the clock edge on which `bus_sel` and `bus_wr` are both high. All accesses are 32-bit. The upper end of the window holds a fixed identification table. Two test locations and every other unmapped offset read as zero. Each channel's interrupt is brought out on its own pin, and a combined pin carries the OR of the two.

Within a channel, the word index is the offset bits [4:2]:
- 0: reload value. A write sets it and also loads the count.
- 1: current count. This location is read-only.
- 2: configuration. Bit 0 selects single-shot. Bit 1 selects 32-bit width, otherwise 16-bit. Bits 3:2 select the prescaler (0 or 3: /1, 1: /16, 2: /256). Bit 5 enables the interrupt. Bit 6 selects periodic. Bit 7 is run.
- 3: a write clears the interrupt.
- 4: raw interrupt.
- 5: masked interrupt.
- 6: shadow reload. A write sets the reload value only.

Top module: `dual_timer_wrap`

## Requirements
- R1: Offsets 0x000-0x01F address channel 0, whose register is chosen by offset bits [4:2] (index 0 reload, 1 count, 2 config, 3 clear, 4 raw, 5 masked, 6 shadow reload). Indexes 3 and 7 read as zero.
- R2: Offsets 0x020-0x03F address channel 1 with 0x20 subtracted, using the same register indexes.
- R3: Offsets 0xFE0-0xFFC read, one byte per word in ascending order, 0x04, 0x18, 0x14, 0x00, 0x0D, 0xF0, 0x05, 0xB1, zero-extended to 32 bits.
- R4: Reads of the test offsets 0xF00 and 0xF04, and of every other offset from 0x040 up to 0xFDF, return zero.
- R5: Writes to any offset from 0x040 to 0xFFF change no channel register and no interrupt output.
- R6: `irq_ch[n]` is high when channel n's raw interrupt and its enable (config bit 5) are both set. `irq_any` is the OR of both channel interrupts.
- R7: A running channel advances only on cycles where its own `tick_en` bit is high. A tick on one channel leaves the other channel unchanged.
- R8: Address bits [1:0] are ignored on reads and writes.
- R9: After reset, each channel reads config 0x20, count 0, reload 0, and raw interrupt 0.
- R10: A step taken while the count is zero sets the raw interrupt. Single-shot mode (bit 0) then holds zero and clears run. Periodic mode (bit 6) reloads the reload value. Free-running mode (bits 0 and 6 clear) reloads 0xFFFF, or 0xFFFFFFFF when bit 1 is set. In 16-bit mode, a written count is truncated to 16 bits.
- R11: A write to index 3 clears the raw interrupt. Index 5 reads the raw interrupt ANDed with the enable.
- R12: Prescaler setting 1 takes one step per 16 ticks and setting 2 one step per 256 ticks. A config write restarts the prescaler.
- R13: A write to index 6 sets the reload value without changing the count.
- R14: Writes to index 1 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_en | input | 2 | Per-channel tick qualifier |
| bus_sel | input | 1 | Access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte offset within the window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid while bus_sel is high |
| irq_ch | output | 2 | Per-channel masked interrupt |
| irq_any | output | 1 | OR of both channel interrupts |

## Verification
The properties take for granted the following. Reset is asserted before the first access. `bus_wr` has meaning only while `bus_sel` is high. A count can change only through a reload write or a qualified tick, so a cycle with no tick and no write must leave it alone. The stimulus follows these rules by holding strobes for exactly one cycle and changing them only on the falling edge. Ticks are applied only while the bus is idle. Random offsets and data are drawn only from the unmapped region or from the reload locations, so every expected value stays computable from the register model.

// File: rtl/dtw_pkg.sv
package dtw_pkg;
  localparam int DATA_W    = 32;
  localparam int ADDR_W    = 12;
  localparam int NUM_CH    = 2;
  localparam int CH_SPAN_W = 5;   // 32 bytes per channel window
  localparam int ID_LSB    = 5;   // identification table is the top 32 bytes
  localparam int IDX_W     = 3;
  localparam int CFG_W     = 8;
  localparam int NARROW_W  = 16;
  localparam int PRE_W     = 8;

  // configuration bit positions
  localparam int CFG_ONESHOT  = 0;
  localparam int CFG_WIDE     = 1;
  localparam int CFG_PRE_LO   = 2;
  localparam int CFG_PRE_HI   = 3;
  localparam int CFG_IRQEN    = 5;
  localparam int CFG_PERIODIC = 6;
  localparam int CFG_RUN      = 7;
  localparam logic [CFG_W-1:0] CFG_RESET = CFG_W'(1 << CFG_IRQEN);

  // register indexes inside a channel
  localparam logic [IDX_W-1:0] IDX_RELOAD = 3'd0;
  localparam logic [IDX_W-1:0] IDX_COUNT  = 3'd1;
  localparam logic [IDX_W-1:0] IDX_CFG    = 3'd2;
  localparam logic [IDX_W-1:0] IDX_ACK    = 3'd3;
  localparam logic [IDX_W-1:0] IDX_RAW    = 3'd4;
  localparam logic [IDX_W-1:0] IDX_MASKED = 3'd5;
  localparam logic [IDX_W-1:0] IDX_SHADOW = 3'd6;

  function automatic logic [7:0] id_byte(input logic [2:0] i);
    case (i)
      3'd0:    id_byte = 8'h04;
      3'd1:    id_byte = 8'h18;
      3'd2:    id_byte = 8'h14;
      3'd3:    id_byte = 8'h00;
      3'd4:    id_byte = 8'h0D;
      3'd5:    id_byte = 8'hF0;
      3'd6:    id_byte = 8'h05;
      default: id_byte = 8'hB1;
    endcase
  endfunction
endpackage

// File: rtl/dtw_id_rom.sv
module dtw_id_rom
  import dtw_pkg::*;
(
  input  logic [2:0] idx,
  output logic [7:0] id_val
);
  always_comb id_val = id_byte(idx);
endmodule

// File: rtl/dtw_decode.sv
module dtw_decode
  import dtw_pkg::*;
#(
  parameter int AW   = ADDR_W,
  parameter int NCH  = NUM_CH,
  parameter int SPAN = CH_SPAN_W,
  localparam int SEL_W = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int UP_W  = AW - SPAN
)(
  input  logic             bus_sel,
  input  logic             bus_wr,
  input  logic [AW-1:0]    bus_addr,
  output logic             ch_hit,
  output logic [SEL_W-1:0] ch_num,
  output logic [IDX_W-1:0] ch_idx,
  output logic [NCH-1:0]   ch_wr,
  output logic             id_hit,
  output logic [2:0]       id_idx
);
  logic [UP_W-1:0] upper;
  logic            unused_lo;

  assign unused_lo = ^bus_addr[1:0];   // word accesses only
  assign upper     = bus_addr[AW-1:SPAN];
  assign ch_hit    = (upper < UP_W'(NCH));
  assign ch_num    = upper[SEL_W-1:0];
  assign ch_idx    = bus_addr[SPAN-1:2];
  assign id_hit    = (bus_addr[AW-1:ID_LSB] == '1);
  assign id_idx    = bus_addr[ID_LSB-1:2];

  for (genvar n = 0; n < NCH; n++) begin : g_wr
    assign ch_wr[n] = bus_sel && bus_wr && ch_hit && (ch_num == SEL_W'(n));
  end
endmodule

// File: rtl/dtw_channel.sv
module dtw_channel
  import dtw_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int PW = PRE_W
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  input  logic             reg_wr,
  input  logic [IDX_W-1:0] reg_idx,
  input  logic [DW-1:0]    reg_wdata,
  output logic [DW-1:0]    reg_rdata,
  output logic             irq
);
  localparam logic [DW-1:0] NARROW_MASK = {{(DW-NARROW_W){1'b0}}, {NARROW_W{1'b1}}};
  localparam logic [PW-1:0] PRE_LIM16   = PW'(15);
  localparam logic [PW-1:0] PRE_LIM256  = PW'(255);

  logic [DW-1:0]    limit_q, count_q, count_d, width_mask;
  logic [CFG_W-1:0] cfg_q, cfg_d;
  logic [PW-1:0]    pre_q, pre_d, pre_lim;
  logic             raw_q, raw_d;
  logic             running, step, expire;
  logic             wr_reload, wr_cfg, wr_ack, wr_shadow;

  assign running    = cfg_q[CFG_RUN];
  assign width_mask = cfg_q[CFG_WIDE] ? '1 : NARROW_MASK;
  assign wr_reload  = reg_wr && (reg_idx == IDX_RELOAD);
  assign wr_cfg     = reg_wr && (reg_idx == IDX_CFG);
  assign wr_ack     = reg_wr && (reg_idx == IDX_ACK);
  assign wr_shadow  = reg_wr && (reg_idx == IDX_SHADOW);

  always_comb begin
    case (cfg_q[CFG_PRE_HI:CFG_PRE_LO])
      2'd1:    pre_lim = PRE_LIM16;
      2'd2:    pre_lim = PRE_LIM256;
      default: pre_lim = '0;
    endcase
  end

  assign step   = running && tick_en && (pre_q == pre_lim);
  assign expire = step && (count_q == '0);

  // prescaler
  always_comb begin
    pre_d = pre_q;
    if (wr_cfg)                    pre_d = '0;
    else if (running && tick_en)   pre_d = step ? '0 : pre_q + PW'(1);
  end

  // counter
  always_comb begin
    count_d = count_q;
    if (wr_reload) begin
      count_d = reg_wdata & width_mask;
    end else if (step) begin
      if (count_q != '0)              count_d = count_q - DW'(1);
      else if (cfg_q[CFG_ONESHOT])    count_d = '0;
      else if (cfg_q[CFG_PERIODIC])   count_d = limit_q & width_mask;
      else                            count_d = width_mask;
    end
  end

  always_comb begin
    cfg_d = cfg_q;
    if (wr_cfg)                               cfg_d = reg_wdata[CFG_W-1:0];
    else if (expire && cfg_q[CFG_ONESHOT])    cfg_d[CFG_RUN] = 1'b0;
  end

  always_comb begin
    raw_d = raw_q;
    if (expire)      raw_d = 1'b1;
    else if (wr_ack) raw_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      limit_q <= '0;
      count_q <= '0;
      cfg_q   <= CFG_RESET;
      pre_q   <= '0;
      raw_q   <= 1'b0;
    end else begin
      if (wr_reload || wr_shadow) limit_q <= reg_wdata;
      count_q <= count_d;
      cfg_q   <= cfg_d;
      pre_q   <= pre_d;
      raw_q   <= raw_d;
    end
  end

  always_comb begin
    case (reg_idx)
      IDX_RELOAD, IDX_SHADOW: reg_rdata = limit_q;
      IDX_COUNT:              reg_rdata = count_q;
      IDX_CFG:                reg_rdata = {{(DW-CFG_W){1'b0}}, cfg_q};
      IDX_RAW:                reg_rdata = {{(DW-1){1'b0}}, raw_q};
      IDX_MASKED:             reg_rdata = {{(DW-1){1'b0}}, raw_q & cfg_q[CFG_IRQEN]};
      default:                reg_rdata = '0;
    endcase
  end

  assign irq = raw_q & cfg_q[CFG_IRQEN];

  // R11: a clear write with no expiry that cycle drops the raw flag
  a_r11_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ack && !expire) |=> !raw_q);
  // R14: a count write on a stopped channel leaves the count alone
  a_r14_count_ro: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_idx == IDX_COUNT && !running) |=> $stable(count_q));
  // R7: no tick and no write leaves the count alone
  a_r7_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_en && !reg_wr) |=> $stable(count_q));
  // R10: single-shot expiry halts the channel
  a_r10_oneshot_halts: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && cfg_q[CFG_ONESHOT] && !reg_wr) |=> !cfg_q[CFG_RUN]);
  // R13: a shadow write on a stopped channel keeps the count
  a_r13_shadow_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_shadow && !running) |=> $stable(count_q));
endmodule

// File: rtl/dual_timer_wrap.sv
module dual_timer_wrap
  import dtw_pkg::*;
#(
  parameter int DW   = DATA_W,
  parameter int AW   = ADDR_W,
  parameter int NCH  = NUM_CH,
  parameter int SPAN = CH_SPAN_W,
  localparam int SEL_W = (NCH > 1) ? $clog2(NCH) : 1
)(
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] tick_en,
  input  logic           bus_sel,
  input  logic           bus_wr,
  input  logic [AW-1:0]  bus_addr,
  input  logic [DW-1:0]  bus_wdata,
  output logic [DW-1:0]  bus_rdata,
  output logic [NCH-1:0] irq_ch,
  output logic           irq_any
);
  localparam logic [AW-1:0] CH_END = AW'(NCH << SPAN);

  logic             ch_hit, id_hit;
  logic [SEL_W-1:0] ch_num;
  logic [IDX_W-1:0] ch_idx;
  logic [NCH-1:0]   ch_wr;
  logic [2:0]       id_idx;
  logic [7:0]       id_val;
  logic [DW-1:0]    ch_rdata [NCH];

  dtw_decode #(.AW(AW), .NCH(NCH), .SPAN(SPAN)) u_decode (
    .bus_sel (bus_sel),
    .bus_wr  (bus_wr),
    .bus_addr(bus_addr),
    .ch_hit  (ch_hit),
    .ch_num  (ch_num),
    .ch_idx  (ch_idx),
    .ch_wr   (ch_wr),
    .id_hit  (id_hit),
    .id_idx  (id_idx)
  );

  dtw_id_rom u_id (.idx(id_idx), .id_val(id_val));

  for (genvar n = 0; n < NCH; n++) begin : g_ch
    dtw_channel #(.DW(DW)) u_ch (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick_en  (tick_en[n]),
      .reg_wr   (ch_wr[n]),
      .reg_idx  (ch_idx),
      .reg_wdata(bus_wdata),
      .reg_rdata(ch_rdata[n]),
      .irq      (irq_ch[n])
    );
  end

  assign irq_any = |irq_ch;

  always_comb begin
    if (!bus_sel)     bus_rdata = '0;
    else if (ch_hit)  bus_rdata = ch_rdata[ch_num];
    else if (id_hit)  bus_rdata = {{(DW-8){1'b0}}, id_val};
    else              bus_rdata = '0;
  end

  // R5: an access above the channel windows strobes no channel
  a_r5_no_stray_write: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_wr && bus_addr >= CH_END) |-> (ch_wr == '0));
  // R3: identification reads carry a single byte
  a_r3_id_byte_only: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_wr && bus_addr[AW-1:ID_LSB] == '1) |-> (bus_rdata[DW-1:8] == '0));
  // R4: unmapped reads return zero
  a_r4_hole_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_wr && bus_addr >= CH_END && bus_addr[AW-1:ID_LSB] != '1)
      |-> (bus_rdata == '0));
endmodule

// File: tb/dual_timer_wrap_bench.sv
module dual_timer_wrap_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  tick_en = '0;
  logic        bus_sel = 1'b0;
  logic        bus_wr = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [1:0]  irq_ch;
  logic        irq_any;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dual_timer_wrap u_dual_timer_wrap (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_ch(irq_ch), .irq_any(irq_any)
  );

  function automatic logic [31:0] exp_static(input logic [11:0] a);
    logic [7:0] tbl [8] = '{8'h04, 8'h18, 8'h14, 8'h00, 8'h0D, 8'hF0, 8'h05, 8'hB1};
    if (a >= 12'hFE0) return {24'h0, tbl[a[4:2]]};
    return 32'h0;
  endfunction

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%08h expected=%08h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    bus_sel = 1'b0;
  endtask

  task automatic rd_chk(input string tag, input logic [11:0] a, input logic [31:0] exp);
    logic [31:0] d;
    rd(a, d);
    check(tag, d, exp);
  endtask

  task automatic ticks(input logic [1:0] m, input int n);
    @(negedge clk);
    tick_en = m;
    repeat (n) @(negedge clk);
    tick_en = '0;
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog (all requirements) actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R9: reset state of both channels
    for (int c = 0; c < 2; c++) begin
      rd_chk("R9 cfg", 12'(c*32 + 8), 32'h20);
      rd_chk("R9 count", 12'(c*32 + 4), 32'h0);
      rd_chk("R9 reload", 12'(c*32 + 0), 32'h0);
      rd_chk("R9 raw", 12'(c*32 + 16), 32'h0);
    end
    check("R9 irq", {29'h0, irq_any, irq_ch}, 32'h0);

    // R4/R3/R8: random reads above the channel windows
    for (int i = 0; i < 300; i++) begin
      logic [11:0] a = 12'($urandom_range(12'hFFF, 12'h040));
      rd(a, d);
      check("R4/R3/R8 random read", d, exp_static({a[11:2], 2'b00}));
    end
    for (int k = 0; k < 8; k++)
      rd_chk("R3 id table", 12'hFE0 + 12'(k*4), exp_static(12'hFE0 + 12'(k*4)));
    rd_chk("R4 test ctrl", 12'hF00, 32'h0);
    rd_chk("R4 test out", 12'hF04, 32'h0);
    rd_chk("R1 index 3 reads zero", 12'h00C, 32'h0);
    rd_chk("R2 index 7 reads zero", 12'h03C, 32'h0);

    // R5: random writes outside channel windows change nothing
    for (int i = 0; i < 150; i++)
      wr(12'($urandom_range(12'hFFF, 12'h040)), $urandom);
    wr(12'hFE0, 32'hFFFF_FFFF);
    for (int c = 0; c < 2; c++) begin
      rd_chk("R5 cfg", 12'(c*32 + 8), 32'h20);
      rd_chk("R5 reload", 12'(c*32), 32'h0);
      rd_chk("R5 count", 12'(c*32 + 4), 32'h0);
      rd_chk("R5 raw", 12'(c*32 + 16), 32'h0);
    end
    rd_chk("R5 id intact", 12'hFE0, 32'h04);
    check("R5 irq", {29'h0, irq_any, irq_ch}, 32'h0);

    // R1/R2/R8: random reload values with random low address bits
    for (int i = 0; i < 20; i++) begin
      logic [31:0] v = $urandom;
      int c = i % 2;
      wr(12'(c*32) | 12'($urandom_range(3, 0)), v);
      rd_chk(c == 0 ? "R1 reload" : "R2 reload", 12'(c*32 + 24) | 12'($urandom_range(3, 0)), v);
      rd_chk(c == 0 ? "R1/R10 narrow count" : "R2/R10 narrow count", 12'(c*32 + 4), v & 32'hFFFF);
    end

    // R10 periodic on channel 0
    wr(12'h000, 32'd5);
    wr(12'h008, 32'hE0);
    ticks(2'b01, 6);
    rd_chk("R10 periodic reload", 12'h004, 32'd5);
    rd_chk("R11 raw", 12'h010, 32'h1);
    rd_chk("R11 masked", 12'h014, 32'h1);
    check("R6 irq after ch0 expiry", {29'h0, irq_any, irq_ch}, 32'b101);
    wr(12'h00C, 32'h0);
    rd_chk("R11 cleared", 12'h010, 32'h0);
    check("R6 irq after clear", {29'h0, irq_any, irq_ch}, 32'h0);
    wr(12'h008, 32'h20);

    // R10 single-shot on channel 1
    wr(12'h020, 32'd2);
    wr(12'h028, 32'hA1);
    ticks(2'b10, 3);
    rd_chk("R10 oneshot count", 12'h024, 32'h0);
    rd_chk("R10 oneshot run cleared", 12'h028, 32'h21);
    check("R6 ch1 irq", {29'h0, irq_any, irq_ch}, 32'b110);
    ticks(2'b10, 2);
    rd_chk("R10 oneshot stays", 12'h024, 32'h0);
    wr(12'h02C, 32'h0);
    check("R11 ch1 cleared", {29'h0, irq_any, irq_ch}, 32'h0);

    // R13 / R14 on channel 1 (stopped)
    wr(12'h038, 32'h77);
    rd_chk("R13 shadow reload", 12'h020, 32'h77);
    rd_chk("R13 count kept", 12'h024, 32'h0);
    wr(12'h024, 32'h55);
    rd_chk("R14 count write ignored", 12'h024, 32'h0);

    // R10 free-running narrow and wide on channel 0
    wr(12'h000, 32'h1);
    wr(12'h008, 32'hA0);
    ticks(2'b01, 2);
    rd_chk("R10 free narrow wrap", 12'h004, 32'hFFFF);
    wr(12'h008, 32'h22);
    wr(12'h000, 32'h0);
    wr(12'h008, 32'hA2);
    ticks(2'b01, 1);
    rd_chk("R10 free wide wrap", 12'h004, 32'hFFFF_FFFF);
    wr(12'h008, 32'h22);
    wr(12'h00C, 32'h0);
    wr(12'h008, 32'h20);

    // R12 prescaler
    wr(12'h000, 32'd10);
    wr(12'h008, 32'hE4);
    ticks(2'b01, 31);
    rd_chk("R12 div16 before", 12'h004, 32'd9);
    ticks(2'b01, 1);
    rd_chk("R12 div16 after", 12'h004, 32'd8);
    wr(12'h000, 32'd3);
    wr(12'h008, 32'hE8);
    ticks(2'b01, 255);
    rd_chk("R12 div256 before", 12'h004, 32'd3);
    ticks(2'b01, 1);
    rd_chk("R12 div256 after", 12'h004, 32'd2);
    wr(12'h008, 32'h20);

    // R7 independent ticks
    wr(12'h000, 32'd100);
    wr(12'h020, 32'd100);
    wr(12'h008, 32'hC0);
    wr(12'h028, 32'hC0);
    ticks(2'b01, 7);
    rd_chk("R7 ch0 advanced", 12'h004, 32'd93);
    rd_chk("R7 ch1 held", 12'h024, 32'd100);
    ticks(2'b10, 3);
    rd_chk("R7 ch1 advanced", 12'h024, 32'd97);
    rd_chk("R7 ch0 held", 12'h004, 32'd93);
    ticks(2'b11, 4);
    rd_chk("R7 ch0 both", 12'h004, 32'd89);
    rd_chk("R7 ch1 both", 12'h024, 32'd93);

    // R6 merge with per-channel enable
    wr(12'h000, 32'd0);
    wr(12'h020, 32'd0);
    wr(12'h008, 32'hE0);
    wr(12'h028, 32'hC0);
    ticks(2'b11, 1);
    check("R6 only enabled channel", {29'h0, irq_any, irq_ch}, 32'b101);
    rd_chk("R11 ch1 raw set", 12'h030, 32'h1);
    rd_chk("R11 ch1 masked off", 12'h034, 32'h0);
    wr(12'h028, 32'hE0);
    check("R6 both", {29'h0, irq_any, irq_ch}, 32'b111);
    wr(12'h00C, 32'h0);
    check("R6 ch1 keeps any", {29'h0, irq_any, irq_ch}, 32'b110);
    wr(12'h02C, 32'h0);
    check("R6 none", {29'h0, irq_any, irq_ch}, 32'h0);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule